// File: doc/BRIEF.md
# Fault-Injectable Single-Port RAM

This block is a synthesizable 64-word by 32-bit single-port RAM. It can be told to misbehave in a chosen way, so that a memory self-test engine can be run against it and its detection rate measured. On the normal side it has an address, write data, a write strobe and a registered read port. A side-band set of configuration inputs loads exactly one fault at a time. A fault is described by its kind, a victim cell and bit, an aggressor cell and bit, a trigger direction, a forced value and an aggressor level.

The supported fault kinds are:
- Stuck bits and blocked transitions on the victim bit.
- Three coupling types, in which the aggressor bit disturbs the victim bit.
- Wired AND or wired OR shorts between the two bits.
- Four address-steering defects, using the victim and aggressor word addresses.

Faults act at the moment a write is applied or when a read word is formed. A self-test engine therefore sees them only through ordinary reads and writes.

On a cycle with the write strobe low, the word at the address is latched into the read register. The read data appears one clock later. On a write cycle the read register holds its value.

Top module: `fault_ram`

## Requirements
- R1: After reset all stored words are zero, the read register is zero and the loaded fault kind is 0 (none).
- R2: With kind 0, the block is an ideal RAM. A write stores the word. A non-write cycle presents the addressed word on rdData after the next clock edge. On write cycles rdData keeps its previous value.
- R3: Kind 1 (stuck at 0) and kind 2 (stuck at 1) make the victim bit read as 0 or 1 at the victim word. A write to that word stores the stuck value, so the value remains after the fault is cleared.
- R4: Kind 3 prevents a write from changing the stored victim bit from 0 to 1. Kind 4 prevents a change from 1 to 0. The other bits of the word are written normally.
- R5: Kind 5 (inversion coupling) inverts the stored victim bit on every write that changes the aggressor bit in the selected direction. cfgRise=1 selects 0 to 1, and cfgRise=0 selects 1 to 0. Writes that cause no such change leave the victim bit unchanged.
- R6: Kind 6 (idempotent coupling) sets the stored victim bit to cfgValue on each aggressor change in the selected direction.
- R7: Kind 7 (state coupling) makes the victim bit read as cfgValue only while the stored aggressor bit equals cfgLevel. The stored victim bit is not altered.
- R8: Kind 8 makes the victim bit and the aggressor bit both read as the AND of their stored values. Kind 9 makes both read as their OR.
- R9: Kind 10 (address reaches no cell): writes to the victim address are dropped, and reads of the victim address return zero.
- R10: Kind 11 (cell reached by no address): the victim address is steered to the aggressor cell for both reads and writes. The victim cell is left untouched.
- R11: Kind 12 (address reaches two cells): a write to the victim address updates both the victim and the aggressor cells. A read of the victim address returns the AND of the two words.
- R12: Kind 13 (cell reached by two addresses): the aggressor address is steered onto the victim cell. The aggressor cell is then unreachable. Kinds 14 and 15 behave as kind 0.
- R13: A configuration load is taken only on a cycle with wrEn low. A load on a write cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Write strobe for the addressed word |
| addr | input | 6 | Word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| cfgLoad | input | 1 | Load the fault description |
| cfgKind | input | 4 | Fault kind code |
| cfgVicAddr | input | 6 | Victim word address |
| cfgVicBit | input | 5 | Victim bit position |
| cfgAggAddr | input | 6 | Aggressor word address |
| cfgAggBit | input | 5 | Aggressor bit position |
| cfgRise | input | 1 | Coupling trigger direction: 1 = rising, 0 = falling |
| cfgValue | input | 1 | Forced value for coupling faults |
| cfgLevel | input | 1 | Aggressor level that enables state coupling |

## Verification
The stuck-at and no-cell properties assume that the fault description does not change on the edge that captures the read. They exclude cycles with cfgLoad high so that a new fault does not race the read it is checked against. The read-hold property relies on wrEn alone, which needs no assumption about the data inputs.

The stimulus loads a fault only on cycles without a write, with one exception: the single deliberate overlap that tests the load lock. It also places victim and aggressor in distinct words, so that only one defect shapes each access.

// File: rtl/fault_ram_pkg.sv
package fault_ram_pkg;

  localparam int unsigned FR_WORDS = 64;
  localparam int unsigned FR_DW    = 32;
  localparam int unsigned FR_AW    = $clog2(FR_WORDS);
  localparam int unsigned FR_BW    = $clog2(FR_DW);

  typedef enum logic [3:0] {
    FK_NONE    = 4'd0,
    FK_SA0     = 4'd1,
    FK_SA1     = 4'd2,
    FK_TF_UP   = 4'd3,
    FK_TF_DN   = 4'd4,
    FK_CF_INV  = 4'd5,
    FK_CF_IDEM = 4'd6,
    FK_CF_ST   = 4'd7,
    FK_BR_AND  = 4'd8,
    FK_BR_OR   = 4'd9,
    FK_AD_NONE = 4'd10,
    FK_AD_ORPH = 4'd11,
    FK_AD_MULT = 4'd12,
    FK_AD_ALIA = 4'd13
  } faultKind_e;

  typedef struct packed {
    faultKind_e       kind;
    logic [FR_AW-1:0] vicAddr;
    logic [FR_BW-1:0] vicBit;
    logic [FR_AW-1:0] aggAddr;
    logic [FR_BW-1:0] aggBit;
    logic             rise;
    logic             val;
    logic             level;
  } faultCfg_t;

  // Victim and aggressor locations, derived only from the loaded fault
  typedef struct packed {
    logic [FR_AW-1:0] vicIdx;
    logic [FR_DW-1:0] vicMask;
    logic [FR_AW-1:0] aggIdx;
    logic [FR_DW-1:0] aggMask;
  } cellSel_t;

  // Per-cycle strobes from control to the storage datapath
  typedef struct packed {
    logic             wrA;
    logic [FR_AW-1:0] wrAIdx;
    logic             wrB;
    logic [FR_AW-1:0] wrBIdx;
    logic [FR_AW-1:0] rdAIdx;
    logic             rdB;
    logic [FR_AW-1:0] rdBIdx;
    logic             rdNull;
    logic             rdLatch;
    logic             adjForce;
    logic             adjVal;
    logic             blkRise;
    logic             blkFall;
    logic             cplEn;
    logic             cplFlip;
    logic             cplVal;
    logic             patVEn;
    logic             patVVal;
    logic             patAEn;
    logic             patAVal;
  } ramStrobe_t;

endpackage

// File: rtl/fault_ram_ctrl.sv
module fault_ram_ctrl
  import fault_ram_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [FR_AW-1:0] addr,
  input  logic [FR_DW-1:0] wrData,
  input  logic             cfgLoad,
  input  faultCfg_t        cfgIn,
  input  logic             vicBitNow,
  input  logic             aggBitNow,
  output faultCfg_t        cfgQ,
  output cellSel_t         sel,
  output ramStrobe_t       st
);

  logic vicHit;
  logic aggHit;
  logic aggNew;
  logic edgeSeen;

  // Fault description register; loads are locked out during writes
  always_ff @(posedge clk) begin
    if (rst) begin
      cfgQ <= '0;
    end else if (cfgLoad && !wrEn) begin
      cfgQ <= cfgIn;
    end
  end

  always_comb begin
    sel.vicIdx  = cfgQ.vicAddr;
    sel.aggIdx  = cfgQ.aggAddr;
    sel.vicMask = FR_DW'(1) << cfgQ.vicBit;
    sel.aggMask = FR_DW'(1) << cfgQ.aggBit;
  end

  assign vicHit   = (addr == cfgQ.vicAddr);
  assign aggHit   = (addr == cfgQ.aggAddr);
  assign aggNew   = wrData[cfgQ.aggBit];
  assign edgeSeen = cfgQ.rise ? (!aggBitNow && aggNew) : (aggBitNow && !aggNew);

  always_comb begin
    st         = '0;
    st.wrA     = wrEn;
    st.wrAIdx  = addr;
    st.wrBIdx  = addr;
    st.rdAIdx  = addr;
    st.rdBIdx  = addr;
    st.rdLatch = !wrEn;
    case (cfgQ.kind)
      FK_SA0, FK_SA1: begin
        st.adjForce = 1'b1;
        st.adjVal   = (cfgQ.kind == FK_SA1);
        st.patVEn   = 1'b1;
        st.patVVal  = (cfgQ.kind == FK_SA1);
      end
      FK_TF_UP: st.blkRise = 1'b1;
      FK_TF_DN: st.blkFall = 1'b1;
      FK_CF_INV, FK_CF_IDEM: begin
        st.cplEn   = wrEn && aggHit && edgeSeen;
        st.cplFlip = (cfgQ.kind == FK_CF_INV);
        st.cplVal  = cfgQ.val;
      end
      FK_CF_ST: begin
        st.patVEn  = (aggBitNow == cfgQ.level);
        st.patVVal = cfgQ.val;
      end
      FK_BR_AND, FK_BR_OR: begin
        st.patVEn  = 1'b1;
        st.patAEn  = 1'b1;
        st.patVVal = (cfgQ.kind == FK_BR_AND) ? (vicBitNow & aggBitNow)
                                             : (vicBitNow | aggBitNow);
        st.patAVal = st.patVVal;
      end
      FK_AD_NONE: begin
        if (vicHit) begin
          st.wrA    = 1'b0;
          st.rdNull = 1'b1;
        end
      end
      FK_AD_ORPH: begin
        if (vicHit) begin
          st.wrAIdx = cfgQ.aggAddr;
          st.rdAIdx = cfgQ.aggAddr;
        end
      end
      FK_AD_MULT: begin
        if (vicHit) begin
          st.wrB    = wrEn;
          st.wrBIdx = cfgQ.aggAddr;
          st.rdB    = 1'b1;
          st.rdBIdx = cfgQ.aggAddr;
        end
      end
      FK_AD_ALIA: begin
        if (aggHit) begin
          st.wrAIdx = cfgQ.vicAddr;
          st.rdAIdx = cfgQ.vicAddr;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/fault_ram_dp.sv
module fault_ram_dp
  import fault_ram_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [FR_DW-1:0] wrData,
  input  cellSel_t         sel,
  input  ramStrobe_t       st,
  output logic             vicBitNow,
  output logic             aggBitNow,
  output logic [FR_DW-1:0] rdData
);

  logic [FR_DW-1:0] mem      [FR_WORDS];
  logic [FR_DW-1:0] nextWord [FR_WORDS];
  logic [FR_DW-1:0] wordA;
  logic [FR_DW-1:0] wordB;
  logic [FR_DW-1:0] rdWord;

  assign vicBitNow = |(mem[sel.vicIdx] & sel.vicMask);
  assign aggBitNow = |(mem[sel.aggIdx] & sel.aggMask);

  // Next value of every word: write, victim-bit write policy, coupling disturb
  always_comb begin
    for (int i = 0; i < FR_WORDS; i++) begin
      logic [FR_DW-1:0] w;
      logic             hit;
      logic             isVic;
      w     = mem[i];
      hit   = (st.wrA && st.wrAIdx == FR_AW'(i)) || (st.wrB && st.wrBIdx == FR_AW'(i));
      isVic = (sel.vicIdx == FR_AW'(i));
      if (hit) begin
        w = wrData;
        if (isVic) begin
          if (st.adjForce) w = (w & ~sel.vicMask) | (st.adjVal ? sel.vicMask : '0);
          if (st.blkRise)  w = w & ~(sel.vicMask & ~mem[i]);
          if (st.blkFall)  w = w | (sel.vicMask & mem[i]);
        end
      end
      if (st.cplEn && isVic) begin
        if (st.cplFlip) w = w ^ sel.vicMask;
        else            w = st.cplVal ? (w | sel.vicMask) : (w & ~sel.vicMask);
      end
      nextWord[i] = w;
    end
  end

  // Read-time view faults applied to the two possible read words
  always_comb begin
    wordA = mem[st.rdAIdx];
    wordB = mem[st.rdBIdx];
    if (st.patVEn && st.rdAIdx == sel.vicIdx)
      wordA = (wordA & ~sel.vicMask) | (st.patVVal ? sel.vicMask : '0);
    if (st.patAEn && st.rdAIdx == sel.aggIdx)
      wordA = (wordA & ~sel.aggMask) | (st.patAVal ? sel.aggMask : '0);
    if (st.patVEn && st.rdBIdx == sel.vicIdx)
      wordB = (wordB & ~sel.vicMask) | (st.patVVal ? sel.vicMask : '0);
    if (st.patAEn && st.rdBIdx == sel.aggIdx)
      wordB = (wordB & ~sel.aggMask) | (st.patAVal ? sel.aggMask : '0);
    if (st.rdNull)   rdWord = '0;
    else if (st.rdB) rdWord = wordA & wordB;
    else             rdWord = wordA;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < FR_WORDS; i++) mem[i] <= '0;
      rdData <= '0;
    end else begin
      for (int i = 0; i < FR_WORDS; i++) mem[i] <= nextWord[i];
      if (st.rdLatch) rdData <= rdWord;
    end
  end

endmodule

// File: rtl/fault_ram.sv
module fault_ram
  import fault_ram_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [FR_AW-1:0] addr,
  input  logic [FR_DW-1:0] wrData,
  output logic [FR_DW-1:0] rdData,
  input  logic             cfgLoad,
  input  logic [3:0]       cfgKind,
  input  logic [FR_AW-1:0] cfgVicAddr,
  input  logic [FR_BW-1:0] cfgVicBit,
  input  logic [FR_AW-1:0] cfgAggAddr,
  input  logic [FR_BW-1:0] cfgAggBit,
  input  logic             cfgRise,
  input  logic             cfgValue,
  input  logic             cfgLevel
);

  faultCfg_t  cfgIn;
  faultCfg_t  cfgQ;
  cellSel_t   sel;
  ramStrobe_t st;
  logic       vicBitNow;
  logic       aggBitNow;

  always_comb begin
    cfgIn.kind    = faultKind_e'(cfgKind);
    cfgIn.vicAddr = cfgVicAddr;
    cfgIn.vicBit  = cfgVicBit;
    cfgIn.aggAddr = cfgAggAddr;
    cfgIn.aggBit  = cfgAggBit;
    cfgIn.rise    = cfgRise;
    cfgIn.val     = cfgValue;
    cfgIn.level   = cfgLevel;
  end

  fault_ram_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wrEn      (wrEn),
    .addr      (addr),
    .wrData    (wrData),
    .cfgLoad   (cfgLoad),
    .cfgIn     (cfgIn),
    .vicBitNow (vicBitNow),
    .aggBitNow (aggBitNow),
    .cfgQ      (cfgQ),
    .sel       (sel),
    .st        (st)
  );

  fault_ram_dp u_dp (
    .clk       (clk),
    .rst       (rst),
    .wrData    (wrData),
    .sel       (sel),
    .st        (st),
    .vicBitNow (vicBitNow),
    .aggBitNow (aggBitNow),
    .rdData    (rdData)
  );

endmodule

// File: rtl/fault_ram_chk.sv
module fault_ram_chk
  import fault_ram_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             wrEn,
  input logic [FR_AW-1:0] addr,
  input logic             cfgLoad,
  input logic [FR_DW-1:0] rdData,
  input faultCfg_t        curCfg
);

  // R2: read register holds across a write cycle
  p_rd_hold_r2: assert property (@(posedge clk) disable iff (rst)
    wrEn |=> $stable(rdData));

  // R13: a load presented together with a write leaves the fault unchanged
  p_cfg_locked_r13: assert property (@(posedge clk) disable iff (rst)
    (wrEn && cfgLoad) |=> $stable(curCfg));

  // R3: stuck-at-0 victim bit reads zero
  p_sa0_r3: assert property (@(posedge clk) disable iff (rst)
    (!wrEn && !cfgLoad && curCfg.kind == FK_SA0 && addr == curCfg.vicAddr)
      |=> (rdData[curCfg.vicBit] == 1'b0));

  // R3: stuck-at-1 victim bit reads one
  p_sa1_r3: assert property (@(posedge clk) disable iff (rst)
    (!wrEn && !cfgLoad && curCfg.kind == FK_SA1 && addr == curCfg.vicAddr)
      |=> (rdData[curCfg.vicBit] == 1'b1));

  // R9: an address that reaches no cell reads zero
  p_nocell_r9: assert property (@(posedge clk) disable iff (rst)
    (!wrEn && !cfgLoad && curCfg.kind == FK_AD_NONE && addr == curCfg.vicAddr)
      |=> (rdData == '0));

endmodule

bind fault_ram fault_ram_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .wrEn    (wrEn),
  .addr    (addr),
  .cfgLoad (cfgLoad),
  .rdData  (rdData),
  .curCfg  (cfgQ)
);

// File: tb/fault_ram_tb.sv
module fault_ram_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  localparam logic [3:0] K_NONE = 4'd0,  K_SA0 = 4'd1,  K_SA1 = 4'd2,
                         K_TFU  = 4'd3,  K_TFD = 4'd4,  K_INV = 4'd5,
                         K_IDM  = 4'd6,  K_ST  = 4'd7,  K_AND = 4'd8,
                         K_OR   = 4'd9,  K_NOC = 4'd10, K_ORP = 4'd11,
                         K_MUL  = 4'd12, K_ALI = 4'd13;

  // {isWrite, addr, data, expected read}
  localparam logic [70:0] VEC [8] = '{
    {1'b1, 6'd3,  32'hA5A5A5A5, 32'h0},
    {1'b1, 6'd63, 32'h0F1E2D3C, 32'h0},
    {1'b1, 6'd0,  32'hFFFFFFFF, 32'h0},
    {1'b0, 6'd3,  32'h0,        32'hA5A5A5A5},
    {1'b0, 6'd63, 32'h0,        32'h0F1E2D3C},
    {1'b0, 6'd0,  32'h0,        32'hFFFFFFFF},
    {1'b1, 6'd3,  32'h12345678, 32'h0},
    {1'b0, 6'd3,  32'h0,        32'h12345678}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        cfgLoad = 1'b0;
  logic [3:0]  cfgKind = '0;
  logic [5:0]  cfgVicAddr = '0;
  logic [4:0]  cfgVicBit = '0;
  logic [5:0]  cfgAggAddr = '0;
  logic [4:0]  cfgAggBit = '0;
  logic        cfgRise = 1'b0;
  logic        cfgValue = 1'b0;
  logic        cfgLevel = 1'b0;

  int  checkCnt = 0;
  int  failCnt  = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_ram u_dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .cfgLoad(cfgLoad), .cfgKind(cfgKind),
    .cfgVicAddr(cfgVicAddr), .cfgVicBit(cfgVicBit), .cfgAggAddr(cfgAggAddr),
    .cfgAggBit(cfgAggBit), .cfgRise(cfgRise), .cfgValue(cfgValue),
    .cfgLevel(cfgLevel)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    wrEn = 1'b0; addr = a;
    @(posedge clk); @(negedge clk);
    check(tag, rdData, exp);
  endtask

  task automatic setCfg(input logic [3:0] k, input logic [5:0] va, input logic [4:0] vb,
                        input logic [5:0] aa, input logic [4:0] ab,
                        input logic ri, input logic v, input logic lv);
    cfgLoad = 1'b1; cfgKind = k; cfgVicAddr = va; cfgVicBit = vb;
    cfgAggAddr = aa; cfgAggBit = ab; cfgRise = ri; cfgValue = v; cfgLevel = lv;
    @(posedge clk); @(negedge clk);
    cfgLoad = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset rdData", rdData, 32'h0);
    rd(6'd5, 32'h0, "R1 reset memory");

    // R2: ideal RAM, table walk
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][70]) wr(VEC[i][69:64], VEC[i][63:32]);
      else            rd(VEC[i][69:64], VEC[i][31:0], "R2 table read");
    end
    wr(6'd3, 32'h0);
    check("R2 hold during write", rdData, 32'h12345678);
    rd(6'd3, 32'h0, "R2 read after rewrite");

    // R3: stuck-at
    setCfg(K_SA0, 6'd10, 5'd4, 6'd0, 5'd0, 1'b0, 1'b0, 1'b0);
    wr(6'd10, 32'hFFFFFFFF);
    rd(6'd10, 32'hFFFFFFEF, "R3 stuck0");
    setCfg(K_SA1, 6'd11, 5'd7, 6'd0, 5'd0, 1'b0, 1'b0, 1'b0);
    rd(6'd11, 32'h00000080, "R3 stuck1");
    setCfg(K_NONE, 6'd0, 5'd0, 6'd0, 5'd0, 1'b0, 1'b0, 1'b0);
    rd(6'd10, 32'hFFFFFFEF, "R3 stuck value held");

    // R4: transition faults
    setCfg(K_TFU, 6'd12, 5'd0, 6'd0, 5'd0, 1'b0, 1'b0, 1'b0);
    wr(6'd12, 32'h3);
    rd(6'd12, 32'h2, "R4 up blocked");
    setCfg(K_NONE, 6'd0, 5'd0, 6'd0, 5'd0, 1'b0, 1'b0, 1'b0);
    wr(6'd13, 32'hFFFFFFFF);
    setCfg(K_TFD, 6'd13, 5'd31, 6'd0, 5'd0, 1'b0, 1'b0, 1'b0);
    wr(6'd13, 32'h0);
    rd(6'd13, 32'h80000000, "R4 down blocked");

    // R5: inversion coupling on rising aggressor
    setCfg(K_INV, 6'd21, 5'd9, 6'd20, 5'd2, 1'b1, 1'b0, 1'b0);
    wr(6'd20, 32'h4);
    rd(6'd21, 32'h200, "R5 flip on rise");
    wr(6'd20, 32'h4);
    rd(6'd21, 32'h200, "R5 no change without transition");
    wr(6'd20, 32'h0);
    rd(6'd21, 32'h200, "R5 falling ignored");
    wr(6'd20, 32'h4);
    rd(6'd21, 32'h0, "R5 flip back");

    // R6: idempotent coupling on falling aggressor, forced to 1
    setCfg(K_IDM, 6'd23, 5'd1, 6'd22, 5'd0, 1'b0, 1'b1, 1'b0);
    wr(6'd22, 32'h1);
    rd(6'd23, 32'h0, "R6 rise ignored");
    wr(6'd22, 32'h0);
    rd(6'd23, 32'h2, "R6 forced on fall");

    // R7: state coupling, aggressor level 1 forces victim to 0
    setCfg(K_ST, 6'd25, 5'd3, 6'd24, 5'd5, 1'b0, 1'b0, 1'b1);
    wr(6'd25, 32'hFFFFFFFF);
    rd(6'd25, 32'hFFFFFFFF, "R7 inactive level");
    wr(6'd24, 32'h20);
    rd(6'd25, 32'hFFFFFFF7, "R7 active level");
    wr(6'd24, 32'h0);
    rd(6'd25, 32'hFFFFFFFF, "R7 stored bit intact");

    // R8: bridging
    setCfg(K_AND, 6'd26, 5'd0, 6'd27, 5'd0, 1'b0, 1'b0, 1'b0);
    wr(6'd26, 32'h1);
    wr(6'd27, 32'h0);
    rd(6'd26, 32'h0, "R8 and victim");
    rd(6'd27, 32'h0, "R8 and aggressor");
    setCfg(K_OR, 6'd26, 5'd0, 6'd27, 5'd0, 1'b0, 1'b0, 1'b0);
    rd(6'd27, 32'h1, "R8 or aggressor");
    rd(6'd26, 32'h1, "R8 or victim");

    // R9: address reaches no cell
    setCfg(K_NONE, 6'd0, 5'd0, 6'd0, 5'd0, 1'b0, 1'b0, 1'b0);
    wr(6'd30, 32'h12345678);
    setCfg(K_NOC, 6'd30, 5'd0, 6'd0, 5'd0, 1'b0, 1'b0, 1'b0);
    rd(6'd30, 32'h0, "R9 read empty");
    wr(6'd30, 32'h0000FFFF);
    setCfg(K_NONE, 6'd0, 5'd0, 6'd0, 5'd0, 1'b0, 1'b0, 1'b0);
    rd(6'd30, 32'h12345678, "R9 write dropped");

    // R10: orphaned cell
    wr(6'd31, 32'hAAAA0000);
    wr(6'd32, 32'h00005555);
    setCfg(K_ORP, 6'd31, 5'd0, 6'd32, 5'd0, 1'b0, 1'b0, 1'b0);
    rd(6'd31, 32'h00005555, "R10 steered read");
    wr(6'd31, 32'h11111111);
    setCfg(K_NONE, 6'd0, 5'd0, 6'd0, 5'd0, 1'b0, 1'b0, 1'b0);
    rd(6'd32, 32'h11111111, "R10 steered write");
    rd(6'd31, 32'hAAAA0000, "R10 victim untouched");

    // R11: one address, two cells
    setCfg(K_MUL, 6'd33, 5'd0, 6'd34, 5'd0, 1'b0, 1'b0, 1'b0);
    wr(6'd33, 32'hFF00FF00);
    wr(6'd34, 32'h0000FFFF);
    rd(6'd33, 32'h0000FF00, "R11 and of two words");
    rd(6'd34, 32'h0000FFFF, "R11 second cell");
    setCfg(K_NONE, 6'd0, 5'd0, 6'd0, 5'd0, 1'b0, 1'b0, 1'b0);
    rd(6'd33, 32'hFF00FF00, "R11 victim written");

    // R12: two addresses, one cell
    setCfg(K_ALI, 6'd35, 5'd0, 6'd36, 5'd0, 1'b0, 1'b0, 1'b0);
    wr(6'd36, 32'hCAFEF00D);
    rd(6'd35, 32'hCAFEF00D, "R12 alias lands on victim");
    rd(6'd36, 32'hCAFEF00D, "R12 alias read");
    setCfg(K_NONE, 6'd0, 5'd0, 6'd0, 5'd0, 1'b0, 1'b0, 1'b0);
    rd(6'd36, 32'h0, "R12 aggressor cell untouched");
    setCfg(4'd15, 6'd37, 5'd0, 6'd38, 5'd0, 1'b0, 1'b0, 1'b0);
    wr(6'd37, 32'h5A5A5A5A);
    rd(6'd37, 32'h5A5A5A5A, "R12 unused code acts as none");

    // R13: load during a write is ignored
    setCfg(K_NONE, 6'd0, 5'd0, 6'd0, 5'd0, 1'b0, 1'b0, 1'b0);
    wrEn = 1'b1; addr = 6'd40; wrData = 32'h0;
    cfgLoad = 1'b1; cfgKind = K_SA1; cfgVicAddr = 6'd40; cfgVicBit = 5'd0;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0; cfgLoad = 1'b0;
    rd(6'd40, 32'h0, "R13 load during write ignored");

    finished = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule